// File: doc/BRIEF.md
# Packed Dual-Lane 16-bit Integer ALU

This block is a small SIMD integer unit. Every 32-bit operand it receives is treated as two separate 16-bit lanes, the low lane in bits 15:0 and the high lane in bits 31:16. One operation, chosen by a 10-bit opcode, is applied to both lanes in the same cycle. Nothing carries, borrows or otherwise passes from one lane to the other.

The supported operations are:

- add and subtract, each in a signed and an unsigned form;
- low-half multiply;
- signed and unsigned minimum and maximum;
- left shift, logical right shift and arithmetic right shift;
- multiply-add over three sources, in a signed and an unsigned form.

A saturate input chooses what happens on overflow for add, subtract and multiply-add. When it is clear, those results wrap. When it is set, they saturate to the 16-bit range that matches the operation's signedness.

The result is registered. The output valid flag follows the input valid flag exactly one clock later. The result register loads only when an input is accepted, so it keeps its value between operations.

Top module: `pk16_alu`

## Requirements
- R1: The two 16-bit lanes (bits 15:0 and 31:16) are computed independently. A carry or borrow out of the low lane never reaches the high lane.
- R2: `out_valid` equals the value `in_valid` had on the previous rising clock edge. When `in_valid` is high, the result of that operation appears on `result` in the same cycle that `out_valid` rises.
- R3: With `sat_en` clear, the following results wrap modulo 2^16 in each lane:
  - opcode 0x382 and opcode 0x38A, which add;
  - opcode 0x383 and opcode 0x38B, which subtract `src_b` from `src_a`.
- R4: With `sat_en` set, the add and subtract opcodes saturate each lane:
  - 0x382 and 0x383 clamp to the signed range [-32768, 32767];
  - 0x38A and 0x38B clamp to the unsigned range [0, 65535].
- R5: Opcode 0x381 returns the low 16 bits of each lane's product `src_a*src_b`. `sat_en` has no effect on it.
- R6: Opcode 0x380 (signed) and opcode 0x389 (unsigned) compute `src_a*src_b+src_c` per lane. The result wraps to 16 bits when `sat_en` is clear and saturates by signedness when `sat_en` is set.
- R7: The shift opcodes are 0x384 (left), 0x385 (logical right, zero fill) and 0x386 (arithmetic right, copies lane bit 15). For each of them:
  - the value being shifted is the `src_b` lane;
  - the shift amount is the low 4 bits of the matching `src_a` lane.
- R8: The minimum and maximum opcodes compare the lanes of `src_a` and `src_b` as follows:
  - 0x387 returns the signed maximum;
  - 0x388 returns the signed minimum;
  - 0x38C returns the unsigned maximum;
  - 0x38D returns the unsigned minimum.
- R9: Any opcode other than 0x380 through 0x38D yields a result of zero in both lanes.
- R10: While `in_valid` is low, `result` keeps its previous value whatever the other inputs do.
- R11: While `rst_n` is low, `result` is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 10 | Operation select |
| src_a | input | 32 | First source; holds the shift amounts for shift operations |
| src_b | input | 32 | Second source; holds the shifted value for shift operations |
| src_c | input | 32 | Addend for multiply-add |
| sat_en | input | 1 | Saturate add, subtract and multiply-add instead of wrapping |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 32 | Registered two-lane result |

## Verification
The block's only state is the result register and the valid flag, so any fault shows up on `result` or `out_valid` in the cycle after the operation is accepted. The bench compares both of them against a behavioural lane model on every clock, which means a wrong lane value, a wrong clamp or a leak between lanes is reported at the first cycle it occurs.

A register that fails to hold while `in_valid` is low shows up as a change on `result` during the idle cycles that the bench inserts between operations. The directed cases push each lane separately to its signed and unsigned limits, so that overflow in the two lanes and a leak across the lane boundary are both visible.

// File: rtl/pk16_pkg.sv
package pk16_pkg;

   localparam int OPC_W = 10;

   // Opcode encodings (decoded by pk16_decode, checked by the bench)
   localparam logic [OPC_W-1:0] OPC_MAD_S = 10'h380;
   localparam logic [OPC_W-1:0] OPC_MUL   = 10'h381;
   localparam logic [OPC_W-1:0] OPC_ADD_S = 10'h382;
   localparam logic [OPC_W-1:0] OPC_SUB_S = 10'h383;
   localparam logic [OPC_W-1:0] OPC_SHL   = 10'h384;
   localparam logic [OPC_W-1:0] OPC_SHR   = 10'h385;
   localparam logic [OPC_W-1:0] OPC_SAR   = 10'h386;
   localparam logic [OPC_W-1:0] OPC_MAX_S = 10'h387;
   localparam logic [OPC_W-1:0] OPC_MIN_S = 10'h388;
   localparam logic [OPC_W-1:0] OPC_MAD_U = 10'h389;
   localparam logic [OPC_W-1:0] OPC_ADD_U = 10'h38A;
   localparam logic [OPC_W-1:0] OPC_SUB_U = 10'h38B;
   localparam logic [OPC_W-1:0] OPC_MAX_U = 10'h38C;
   localparam logic [OPC_W-1:0] OPC_MIN_U = 10'h38D;

   typedef enum logic [3:0] {
      K_NONE,
      K_ADD,
      K_SUB,
      K_MUL,
      K_MAD,
      K_SHL,
      K_SHR,
      K_SAR,
      K_MIN,
      K_MAX
   } kind_e;

   typedef struct packed {
      kind_e kind;
      logic  sgn;
   } lane_ctl_t;

endpackage

// File: rtl/pk16_decode.sv
module pk16_decode
   import pk16_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output lane_ctl_t        ctl
);

   always_comb begin
      ctl = '{kind: K_NONE, sgn: 1'b0};
      case (opcode)
         OPC_MAD_S: ctl = '{kind: K_MAD, sgn: 1'b1};
         OPC_MAD_U: ctl = '{kind: K_MAD, sgn: 1'b0};
         OPC_MUL:   ctl = '{kind: K_MUL, sgn: 1'b0};
         OPC_ADD_S: ctl = '{kind: K_ADD, sgn: 1'b1};
         OPC_ADD_U: ctl = '{kind: K_ADD, sgn: 1'b0};
         OPC_SUB_S: ctl = '{kind: K_SUB, sgn: 1'b1};
         OPC_SUB_U: ctl = '{kind: K_SUB, sgn: 1'b0};
         OPC_SHL:   ctl = '{kind: K_SHL, sgn: 1'b0};
         OPC_SHR:   ctl = '{kind: K_SHR, sgn: 1'b0};
         OPC_SAR:   ctl = '{kind: K_SAR, sgn: 1'b1};
         OPC_MAX_S: ctl = '{kind: K_MAX, sgn: 1'b1};
         OPC_MIN_S: ctl = '{kind: K_MIN, sgn: 1'b1};
         OPC_MAX_U: ctl = '{kind: K_MAX, sgn: 1'b0};
         OPC_MIN_U: ctl = '{kind: K_MIN, sgn: 1'b0};
         default:   ctl = '{kind: K_NONE, sgn: 1'b0};
      endcase
   end

endmodule

// File: rtl/pk16_lane.sv
module pk16_lane
   import pk16_pkg::*;
#(
   parameter int LANE_W = 16
) (
   input  lane_ctl_t         ctl,
   input  logic              sat_en,
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic [LANE_W-1:0] c,
   output logic [LANE_W-1:0] y
);

   // Wide enough for a full product plus an addend, in either signedness
   localparam int EXT_W = 2 * LANE_W + 2;
   localparam int SH_W  = $clog2(LANE_W);

   localparam logic signed [EXT_W-1:0] S_HI = {{(EXT_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] S_LO = {{(EXT_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
   localparam logic signed [EXT_W-1:0] U_HI = {{(EXT_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
   localparam logic signed [EXT_W-1:0] U_LO = '0;

   logic signed [EXT_W-1:0]  ea, eb, ec;
   logic signed [EXT_W-1:0]  sum, dif, prd, mac;
   logic signed [LANE_W-1:0] bs;
   logic [SH_W-1:0]          amt;

   // Sign or zero extension chosen by the operation's signedness
   assign ea  = {{(EXT_W-LANE_W){ctl.sgn & a[LANE_W-1]}}, a};
   assign eb  = {{(EXT_W-LANE_W){ctl.sgn & b[LANE_W-1]}}, b};
   assign ec  = {{(EXT_W-LANE_W){ctl.sgn & c[LANE_W-1]}}, c};
   assign sum = ea + eb;
   assign dif = ea - eb;
   assign prd = ea * eb;
   assign mac = prd + ec;
   assign bs  = b;
   assign amt = a[SH_W-1:0];

   function automatic logic [LANE_W-1:0] fit(input logic signed [EXT_W-1:0] v,
                                             input logic sgn, input logic sat);
      logic signed [EXT_W-1:0] hi, lo;
      hi = sgn ? S_HI : U_HI;
      lo = sgn ? S_LO : U_LO;
      if (!sat)        fit = v[LANE_W-1:0];
      else if (v > hi) fit = hi[LANE_W-1:0];
      else if (v < lo) fit = lo[LANE_W-1:0];
      else             fit = v[LANE_W-1:0];
   endfunction

   always_comb begin
      y = '0;
      case (ctl.kind)
         K_ADD:   y = fit(sum, ctl.sgn, sat_en);
         K_SUB:   y = fit(dif, ctl.sgn, sat_en);
         K_MAD:   y = fit(mac, ctl.sgn, sat_en);
         K_MUL:   y = prd[LANE_W-1:0];
         K_SHL:   y = b << amt;
         K_SHR:   y = b >> amt;
         K_SAR:   y = bs >>> amt;
         K_MIN:   y = (ea < eb) ? a : b;
         K_MAX:   y = (ea > eb) ? a : b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/pk16_alu.sv
module pk16_alu
   import pk16_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int LANES  = 2,
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] src_c,
   input  logic              sat_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);

   initial begin : elab_chk
      if (LANE_W < 4 || (LANE_W & (LANE_W - 1)) != 0)
         $fatal(1, "pk16_alu: LANE_W must be a power of two of at least 4");
      if (LANES < 1)
         $fatal(1, "pk16_alu: LANES must be at least 1");
   end

   lane_ctl_t         ctl;
   logic [DATA_W-1:0] lane_y;
   logic [DATA_W-1:0] res_q;
   logic              vld_q;

   pk16_decode u_dec (
      .opcode (opcode),
      .ctl    (ctl)
   );

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      pk16_lane #(.LANE_W(LANE_W)) u_lane (
         .ctl    (ctl),
         .sat_en (sat_en),
         .a      (src_a[gl*LANE_W +: LANE_W]),
         .b      (src_b[gl*LANE_W +: LANE_W]),
         .c      (src_c[gl*LANE_W +: LANE_W]),
         .y      (lane_y[gl*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) res_q <= lane_y;
      end
   end

   assign out_valid = vld_q;
   assign result    = res_q;

endmodule

// File: rtl/pk16_alu_chk.sv
module pk16_alu_chk #(
   parameter int LANE_W = 16,
   parameter int LANES  = 2,
   localparam int DATA_W = LANE_W * LANES
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [9:0]        opcode,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [DATA_W-1:0] src_c,
   input logic              sat_en,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);

   assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opcode < 10'h380 || opcode > 10'h38D)) |=> (result == '0));

   assert_shl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 10'h384 && src_b == '0) |=> (result == '0));

   assert_umad_addend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 10'h389 && !sat_en && src_a == '0) |=> (result == $past(src_c)));

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane_chk
      assert_umin_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == 10'h38D) |=>
            (result[gl*LANE_W +: LANE_W] <= $past(src_a[gl*LANE_W +: LANE_W]) &&
             result[gl*LANE_W +: LANE_W] <= $past(src_b[gl*LANE_W +: LANE_W])));

      assert_usat_add_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == 10'h38A && sat_en) |=>
            (result[gl*LANE_W +: LANE_W] >= $past(src_a[gl*LANE_W +: LANE_W]) &&
             result[gl*LANE_W +: LANE_W] >= $past(src_b[gl*LANE_W +: LANE_W])));
   end

endmodule

bind pk16_alu pk16_alu_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .opcode    (opcode),
   .src_a     (src_a),
   .src_b     (src_b),
   .src_c     (src_c),
   .sat_en    (sat_en),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/tb_pk16_alu.sv
`timescale 1ns/1ps
module tb_pk16_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [9:0]  opcode = '0;
   logic [31:0] src_a = '0, src_b = '0, src_c = '0;
   logic        sat_en = 1'b0;
   logic        out_valid;
   logic [31:0] result;

   int          checks = 0;
   int          errors = 0;
   logic        exp_vld = 1'b0;
   logic [31:0] exp_res = '0;
   string       cur_tag = "R11";

   always #2.5 clk = ~clk;

   pk16_alu dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .src_a(src_a), .src_b(src_b), .src_c(src_c), .sat_en(sat_en),
      .out_valid(out_valid), .result(result)
   );

   function automatic longint sx(longint u);
      return (u >= 32768) ? u - 65536 : u;
   endfunction

   function automatic longint clampv(longint v, longint lo, longint hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   // Behavioural lane model
   function automatic logic [31:0] model(logic [9:0] op, logic [31:0] a, b, c, bit sat);
      logic [31:0] r = '0;
      for (int l = 0; l < 2; l++) begin
         longint ua = (a >> (16*l)) & 32'hFFFF;
         longint ub = (b >> (16*l)) & 32'hFFFF;
         longint uc = (c >> (16*l)) & 32'hFFFF;
         longint v = 0;
         bit s = 0, arith = 0;
         int amt = int'(ua & 15);
         case (op)
            10'h382: begin s = 1; arith = 1; v = sx(ua) + sx(ub); end
            10'h38A: begin arith = 1; v = ua + ub; end
            10'h383: begin s = 1; arith = 1; v = sx(ua) - sx(ub); end
            10'h38B: begin arith = 1; v = ua - ub; end
            10'h380: begin s = 1; arith = 1; v = sx(ua) * sx(ub) + sx(uc); end
            10'h389: begin arith = 1; v = ua * ub + uc; end
            10'h381: v = ua * ub;
            10'h384: v = ub << amt;
            10'h385: v = ub >> amt;
            10'h386: v = sx(ub) >>> amt;
            10'h387: v = (sx(ua) > sx(ub)) ? ua : ub;
            10'h388: v = (sx(ua) < sx(ub)) ? ua : ub;
            10'h38C: v = (ua > ub) ? ua : ub;
            10'h38D: v = (ua < ub) ? ua : ub;
            default: v = 0;
         endcase
         if (arith && sat) v = s ? clampv(v, -32768, 32767) : clampv(v, 0, 65535);
         r[16*l +: 16] = v[15:0];
      end
      return r;
   endfunction

   function automatic string tag_of(logic [9:0] op, bit sat);
      case (op)
         10'h382, 10'h38A, 10'h383, 10'h38B: return sat ? "R4" : "R3";
         10'h381: return "R5";
         10'h380, 10'h389: return "R6";
         10'h384, 10'h385, 10'h386: return "R7";
         10'h387, 10'h388, 10'h38C, 10'h38D: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic compare();
      checks++;
      if (out_valid !== exp_vld) begin
         errors++;
         $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_vld);
      end
      checks++;
      if (result !== exp_res) begin
         errors++;
         $display("FAIL %s result actual=%08h expected=%08h", cur_tag, result, exp_res);
      end
   endtask

   // Compare last cycle's outcome, then drive the next cycle's inputs
   task automatic step(bit v, logic [9:0] op, logic [31:0] a, b, c, bit sat, string tag);
      @(negedge clk);
      compare();
      in_valid = v; opcode = op; src_a = a; src_b = b; src_c = c; sat_en = sat;
      exp_vld = v;
      if (v) exp_res = model(op, a, b, c, sat);
      cur_tag = tag;
   endtask

   task automatic op1(logic [9:0] op, logic [31:0] a, b, c, bit sat);
      step(1'b1, op, a, b, c, sat, tag_of(op, sat));
   endtask

   function automatic logic [15:0] pick16();
      case ($urandom_range(0, 5))
         0: return 16'h0000;
         1: return 16'hFFFF;
         2: return 16'h7FFF;
         3: return 16'h8000;
         4: return 16'h0001;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      // R11: reset state
      repeat (3) @(negedge clk);
      cur_tag = "R11";
      compare();
      rst_n = 1'b1;

      // R1: lane isolation, carry and borrow at the lane boundary
      step(1, 10'h38A, 32'h0001FFFF, 32'h00000001, 0, 0, "R1");
      step(1, 10'h38B, 32'h00010000, 32'h00000001, 0, 0, "R1");
      step(1, 10'h382, 32'h7FFF7FFF, 32'h00010000, 0, 1, "R1");

      // R3 wrap, R4 saturate
      op1(10'h382, 32'h7FFF8000, 32'h0001FFFF, 0, 0);
      op1(10'h382, 32'h7FFF8000, 32'h0001FFFF, 0, 1);
      op1(10'h383, 32'h80007FFF, 32'h0001FFFF, 0, 1);
      op1(10'h38A, 32'hFFFF1234, 32'h00011111, 0, 1);
      op1(10'h38B, 32'h00000005, 32'h00010009, 0, 1);
      op1(10'h38B, 32'h00000005, 32'h00010009, 0, 0);

      // R5: low multiply, saturate ignored
      op1(10'h381, 32'hFFFF0100, 32'hFFFF0100, 0, 0);
      op1(10'h381, 32'hFFFF0100, 32'hFFFF0100, 0, 1);

      // R6: multiply-add
      op1(10'h380, 32'h7FFF8000, 32'h00020002, 32'h00000000, 1);
      op1(10'h380, 32'hFFFF0003, 32'h00050004, 32'h00010002, 0);
      op1(10'h389, 32'hFFFF0100, 32'hFFFF0100, 32'h00010005, 0);
      op1(10'h389, 32'hFFFF0100, 32'hFFFF0100, 32'h00010005, 1);

      // R7: shifts, amount from src_a low 4 bits, value from src_b
      op1(10'h384, 32'h00130004, 32'h8001F00F, 0, 0);
      op1(10'h385, 32'h001F0004, 32'h8000F00F, 0, 0);
      op1(10'h386, 32'h000F0004, 32'h8000700F, 0, 0);

      // R8: min and max
      op1(10'h387, 32'h80000001, 32'h00018000, 0, 0);
      op1(10'h388, 32'h80000001, 32'h00018000, 0, 0);
      op1(10'h38C, 32'h80000001, 32'h00018000, 0, 0);
      op1(10'h38D, 32'h80000001, 32'h00018000, 0, 0);

      // R9: undefined opcodes
      op1(10'h37F, 32'h12345678, 32'h11111111, 0, 0);
      op1(10'h38E, 32'h12345678, 32'h11111111, 0, 1);
      op1(10'h3FF, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0);
      op1(10'h000, 32'h00010001, 32'h00010001, 0, 0);

      // R10: hold while idle
      op1(10'h38A, 32'h00020003, 32'h00040005, 0, 0);
      step(0, 10'h382, 32'hAAAAAAAA, 32'h55555555, 0, 0, "R10");
      step(0, 10'h000, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 1, "R10");

      // Mixed traffic, compared every clock
      for (int i = 0; i < 3000; i++) begin
         logic [9:0] op = 10'h37E + 10'($urandom_range(0, 17));
         bit v = ($urandom_range(0, 3) != 0);
         bit s = $urandom_range(0, 1);
         logic [31:0] a = {pick16(), pick16()};
         logic [31:0] b = {pick16(), pick16()};
         logic [31:0] c = {pick16(), pick16()};
         step(v, op, a, b, c, s, v ? tag_of(op, s) : "R10");
      end

      // R11: reset in the middle of traffic
      op1(10'h38A, 32'h00010001, 32'h00010001, 0, 0);
      @(negedge clk);
      compare();
      rst_n = 1'b0; in_valid = 1'b0;
      exp_vld = 1'b0; exp_res = '0; cur_tag = "R11";
      @(negedge clk);
      compare();
      rst_n = 1'b1;
      step(0, 10'h000, 0, 0, 0, 0, "R11");
      @(negedge clk);
      compare();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule